// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive byte path of an Ethernet MAC and decides, per frame, whether the frame should be kept. It watches the six destination-address bytes as they arrive, one per cycle, and classifies the address: is it unicast, multicast or broadcast, and does it equal the configured station address? While the bytes stream past, it also folds them into a CRC-32 whose six selected bits index a 64-entry multicast hash table.

One cycle after the byte flagged as the last address byte, the block raises a single-cycle decision strobe together with an accept bit. Configuration arrives on plain input ports. The block captures it into internal registers when a load strobe is high. Reset clears every captured setting, so after reset, and before the first load, every frame is rejected.

Top module: `rx_addr_filter`

## Requirements
- R1: `decision_valid` is high for exactly the one cycle that follows a cycle with `addr_valid` and `addr_last` both high, and is low in every other cycle.
- R2: Address bytes arrive in wire order, with byte 0 first. The station address is held in `cfg_station_lo`, which carries bytes 0..3 with byte 0 in bits [7:0], and in `cfg_station_hi`, which carries byte 4 in bits [7:0] and byte 5 in bits [15:8]. With exact matching enabled, a non-broadcast address equal to the station address is accepted, and an address that differs in any byte is not accepted by that rule.
- R3: An address is multicast when bit 0 of byte 0 is 1. With unicast enabled, every address whose byte-0 bit 0 is 0 is accepted.
- R4: With multicast enabled, every multicast address that is not broadcast is accepted.
- R5: An all-ones address is broadcast. It is accepted exactly when broadcast is enabled, whatever the hash table and the other enables hold.
- R6: The hash is computed as follows. The CRC is preset to all ones. Each byte is XORed into the low byte of the CRC, followed by eight right-shift steps; each step XORs in 0xEDB88320 when the bit shifted out is 1. After six bytes the result is complemented, and bits [28:23] of that result form the 6-bit index.
- R7: Index values 0..31 select bit `index` of `cfg_hash_lo`, and values 32..63 select bit `index-32` of `cfg_hash_hi`. With hash enabled, a non-broadcast multicast address whose selected bit is 1 is accepted. A unicast address is never accepted by the hash rule.
- R8: The CRC and all address classification restart with the byte that follows a last byte, so back-to-back frames with no idle cycle each get a decision that does not depend on the previous frame.
- R9: Configuration is captured on a cycle where `cfg_load` is high and is held at all other times. Reset clears all captured enables and both hash words, so frames are rejected until the first load.
- R10: A frame that matches no enabled rule is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Destination address byte, byte 0 first |
| addr_last | input | 1 | Marks the sixth address byte |
| cfg_load | input | 1 | Captures all cfg_* inputs |
| cfg_station_lo | input | 32 | Station address bytes 0..3 |
| cfg_station_hi | input | 16 | Station address bytes 4..5 |
| cfg_hash_lo | input | 32 | Hash table entries 0..31 |
| cfg_hash_hi | input | 32 | Hash table entries 32..63 |
| cfg_en_unicast | input | 1 | Accept any unicast address |
| cfg_en_multicast | input | 1 | Accept any multicast address |
| cfg_en_broadcast | input | 1 | Accept broadcast |
| cfg_en_hash | input | 1 | Accept multicast addresses that hit in the hash table |
| cfg_en_exact | input | 1 | Accept the station address |
| decision_valid | output | 1 | One-cycle decision strobe |
| decision_accept | output | 1 | Frame accepted; meaningful while decision_valid is high |

## Verification
The bench searches for multicast addresses whose index lands in each half of the table. It then loads tables holding only that bit, and tables holding every bit except that one. A wrong CRC preset, polynomial, bit order, index slice or word split shows up here as an accept that should be a reject, or the reverse. Broadcast is sent with a full hash table and the broadcast rule off; a design that lets the hash rule see broadcast would wrongly accept it. Frames are also sent back to back after a frame with unrelated content. A CRC or byte counter that fails to restart after a last byte would carry stale state into the next frame and flip its decision. Station addresses that differ only in byte 0 or only in byte 5 catch a swapped byte order.

// File: rtl/afl_pkg.sv
package afl_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int WORD_W     = 32;
    localparam int HASH_BITS  = 2 * WORD_W;
    localparam int IDX_W      = $clog2(HASH_BITS);
    localparam int IDX_TOP    = 28;
    localparam int CNT_W      = $clog2(ADDR_BYTES);

    localparam logic [WORD_W-1:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [WORD_W-1:0] CRC_PRESET = '1;

    typedef struct packed {
        logic [ADDR_W-1:0]    station;
        logic [HASH_BITS-1:0] table_bits;
        logic                 en_uni;
        logic                 en_multi;
        logic                 en_bcast;
        logic                 en_hash;
        logic                 en_exact;
    } filt_cfg_t;

    typedef struct packed {
        logic is_bcast;
        logic is_multi;
        logic stn_hit;
    } addr_class_t;

    function automatic logic [WORD_W-1:0] crc_fold_byte(input logic [WORD_W-1:0] cur,
                                                        input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = cur ^ {{(WORD_W-BYTE_W){1'b0}}, b};
        for (int s = 0; s < BYTE_W; s++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] hash_slot(input logic [WORD_W-1:0] raw);
        logic [WORD_W-1:0] fin;
        fin = ~raw;
        return fin[IDX_TOP -: IDX_W];
    endfunction

endpackage

// File: rtl/afl_cfg_regs.sv
module afl_cfg_regs
    import afl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  filt_cfg_t cfg_d,
    output filt_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_d;
    end

    // R9: reset leaves an empty table and no enables
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (cfg_q.table_bits == '0 && !cfg_q.en_uni && !cfg_q.en_multi &&
                 !cfg_q.en_bcast && !cfg_q.en_hash && !cfg_q.en_exact));

    // R9: no load, no change
    assert_hold_without_load_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/afl_hash_crc.sv
module afl_hash_crc
    import afl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [IDX_W-1:0]  slot
);

    logic              fresh_q;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] crc_next;

    always_comb begin
        crc_next = crc_fold_byte(fresh_q ? CRC_PRESET : crc_q, in_byte);
        slot     = hash_slot(crc_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b1;
            crc_q   <= CRC_PRESET;
        end else if (in_valid) begin
            fresh_q <= in_last;
            crc_q   <= crc_next;
        end
    end

    // R8: after a last byte, the next frame starts fresh
    assert_restart_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> fresh_q);

endmodule

// File: rtl/afl_addr_track.sv
module afl_addr_track
    import afl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [ADDR_W-1:0] station,
    output addr_class_t       cls
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    logic             fresh_q;
    logic [CNT_W-1:0] pos_q;
    logic             bc_q;
    logic             hit_q;
    logic             mc_q;

    logic [CNT_W-1:0]  pos_eff;
    logic [BYTE_W-1:0] stn_byte;
    logic              pos_ok;

    always_comb begin
        pos_eff  = fresh_q ? '0 : pos_q;
        stn_byte = '0;
        pos_ok   = 1'b0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (pos_eff == CNT_W'(k)) begin
                stn_byte = station[k*BYTE_W +: BYTE_W];
                pos_ok   = 1'b1;
            end
        end
        cls.is_multi = fresh_q ? in_byte[0] : mc_q;
        cls.is_bcast = (fresh_q | bc_q) & (in_byte == '1);
        cls.stn_hit  = (fresh_q | hit_q) & pos_ok & (in_byte == stn_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b1;
            pos_q   <= '0;
            bc_q    <= 1'b0;
            hit_q   <= 1'b0;
            mc_q    <= 1'b0;
        end else if (in_valid) begin
            fresh_q <= in_last;
            pos_q   <= (pos_eff == LAST_POS) ? LAST_POS : pos_eff + 1'b1;
            bc_q    <= cls.is_bcast;
            hit_q   <= cls.stn_hit;
            mc_q    <= cls.is_multi;
        end
    end

    // R3: the multicast flag stays fixed once byte 0 has passed
    assert_multi_latched_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fresh_q && !in_last) |=> (mc_q == $past(mc_q)));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_valid,
    input  logic [7:0]  addr_byte,
    input  logic        addr_last,
    input  logic        cfg_load,
    input  logic [31:0] cfg_station_lo,
    input  logic [15:0] cfg_station_hi,
    input  logic [31:0] cfg_hash_lo,
    input  logic [31:0] cfg_hash_hi,
    input  logic        cfg_en_unicast,
    input  logic        cfg_en_multicast,
    input  logic        cfg_en_broadcast,
    input  logic        cfg_en_hash,
    input  logic        cfg_en_exact,
    output logic        decision_valid,
    output logic        decision_accept
);

    filt_cfg_t   cfg_d;
    filt_cfg_t   cfg_q;
    addr_class_t cls;
    addr_class_t cls_q;
    logic [IDX_W-1:0] slot;
    logic             slot_set;
    logic             accept_now;

    always_comb begin
        cfg_d.station    = {cfg_station_hi, cfg_station_lo};
        cfg_d.table_bits = {cfg_hash_hi, cfg_hash_lo};
        cfg_d.en_uni     = cfg_en_unicast;
        cfg_d.en_multi   = cfg_en_multicast;
        cfg_d.en_bcast   = cfg_en_broadcast;
        cfg_d.en_hash    = cfg_en_hash;
        cfg_d.en_exact   = cfg_en_exact;
    end

    afl_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    afl_hash_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (addr_valid),
        .in_last  (addr_last),
        .in_byte  (addr_byte),
        .slot     (slot)
    );

    afl_addr_track u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (addr_valid),
        .in_last  (addr_last),
        .in_byte  (addr_byte),
        .station  (cfg_q.station),
        .cls      (cls)
    );

    always_comb begin
        slot_set = cfg_q.table_bits[slot];
        if (cls.is_bcast) begin
            accept_now = cfg_q.en_bcast;
        end else begin
            accept_now = (cfg_q.en_uni   & ~cls.is_multi)
                       | (cfg_q.en_multi &  cls.is_multi)
                       | (cfg_q.en_hash  &  cls.is_multi & slot_set)
                       | (cfg_q.en_exact &  cls.stn_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            decision_valid  <= 1'b0;
            decision_accept <= 1'b0;
            cls_q           <= '0;
        end else begin
            decision_valid  <= addr_valid & addr_last;
            decision_accept <= addr_valid & addr_last & accept_now;
            if (addr_valid && addr_last) cls_q <= cls;
        end
    end

    // R1: a last byte always yields a decision on the next cycle
    assert_decision_follows_last_R1: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_last) |=> decision_valid);

    // R1: no decision without a last byte
    assert_no_spurious_decision_R1: assert property (@(posedge clk) disable iff (rst)
        !(addr_valid && addr_last) |=> !decision_valid);

    // R5: broadcast outcome follows only the broadcast enable
    assert_bcast_precedence_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_last && cls.is_bcast) |=>
            (decision_accept == $past(cfg_q.en_bcast)));

    // R3: unicast enable accepts a unicast address
    assert_unicast_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_last && !cls.is_multi && cfg_q.en_uni) |=> decision_accept);

    // R10: nothing enabled, nothing accepted
    assert_all_off_rejects_R10: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && !cls_q.is_bcast &&
         !$past(cfg_q.en_uni) && !$past(cfg_q.en_multi) &&
         !$past(cfg_q.en_hash) && !$past(cfg_q.en_exact)) |-> !decision_accept);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        addr_last = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_station_lo = '0;
    logic [15:0] cfg_station_hi = '0;
    logic [31:0] cfg_hash_lo = '0;
    logic [31:0] cfg_hash_hi = '0;
    logic        cfg_en_unicast = 1'b0;
    logic        cfg_en_multicast = 1'b0;
    logic        cfg_en_broadcast = 1'b0;
    logic        cfg_en_hash = 1'b0;
    logic        cfg_en_exact = 1'b0;
    logic        decision_valid;
    logic        decision_accept;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    always #5ns clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst(rst),
        .addr_valid(addr_valid), .addr_byte(addr_byte), .addr_last(addr_last),
        .cfg_load(cfg_load),
        .cfg_station_lo(cfg_station_lo), .cfg_station_hi(cfg_station_hi),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .cfg_en_unicast(cfg_en_unicast), .cfg_en_multicast(cfg_en_multicast),
        .cfg_en_broadcast(cfg_en_broadcast), .cfg_en_hash(cfg_en_hash),
        .cfg_en_exact(cfg_en_exact),
        .decision_valid(decision_valid), .decision_accept(decision_accept)
    );

    // bit-serial model of the hash index; address byte k sits at bits [8k+7:8k]
    function automatic int model_slot(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[0] ^ a[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        c = ~c;
        return int'(c[28:23]);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // enables: {uni, multi, bcast, hash, exact}
    task automatic load_cfg(input logic [47:0] stn, input logic [63:0] tbl, input logic [4:0] en);
        @(negedge clk);
        cfg_station_lo = stn[31:0];
        cfg_station_hi = stn[47:32];
        cfg_hash_lo    = tbl[31:0];
        cfg_hash_hi    = tbl[63:32];
        {cfg_en_unicast, cfg_en_multicast, cfg_en_broadcast, cfg_en_hash, cfg_en_exact} = en;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic send_addr(input logic [47:0] a, input string req, input logic exp_acc);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_valid = 1'b1;
            addr_byte  = a[k*8 +: 8];
            addr_last  = (k == 5);
        end
        @(negedge clk);
        addr_valid = 1'b0;
        addr_last  = 1'b0;
        check({req, " strobe"}, decision_valid, 1);
        check({req, " accept"}, decision_accept, exp_acc);
    endtask

    task automatic send_pair(input logic [47:0] a, input logic [47:0] b,
                             input logic exp_a, input logic exp_b);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 6) begin
                check("R8 first frame strobe", decision_valid, 1);
                check("R8 first frame accept", decision_accept, exp_a);
            end
            addr_valid = 1'b1;
            addr_byte  = (k < 6) ? a[k*8 +: 8] : b[(k-6)*8 +: 8];
            addr_last  = (k == 5) || (k == 11);
        end
        @(negedge clk);
        addr_valid = 1'b0;
        addr_last  = 1'b0;
        check("R8 second frame strobe", decision_valid, 1);
        check("R8 second frame accept", decision_accept, exp_b);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 strobe low after reset", decision_valid, 0);
        check("R1 accept low after reset", decision_accept, 0);
        send_addr(BCAST, "R9 broadcast rejected before load", 0);
        send_addr(48'h0000_0000_0002, "R9 unicast rejected before load", 0);
        @(negedge clk);
        check("R1 strobe drops after one cycle", decision_valid, 0);
    endtask

    task automatic t_unicast();
        load_cfg(48'h0, 64'h0, 5'b10000);
        send_addr(48'h1234_5678_9A02, "R3 unicast accepted", 1);
        send_addr(48'h1234_5678_9A03, "R3 multicast not unicast", 0);
    endtask

    task automatic t_multicast();
        load_cfg(48'h0, 64'h0, 5'b01000);
        send_addr(48'h1234_5678_9A03, "R4 multicast accepted", 1);
        send_addr(48'h1234_5678_9A02, "R4 unicast not multicast", 0);
        send_addr(BCAST, "R5 broadcast not via multicast", 0);
    endtask

    task automatic t_broadcast();
        load_cfg(48'h0, '1, 5'b11011);
        send_addr(BCAST, "R5 broadcast off rejects despite full table", 0);
        load_cfg(48'h0, '0, 5'b00100);
        send_addr(BCAST, "R5 broadcast accepted", 1);
        send_addr(48'hFFFF_FFFF_FFFE, "R10 near-broadcast rejected", 0);
    endtask

    task automatic t_exact();
        logic [47:0] stn;
        stn = 48'hA1B2_C3D4_E5F6;
        load_cfg(stn, 64'h0, 5'b00001);
        send_addr(stn, "R2 station accepted", 1);
        send_addr(stn ^ 48'h0100_0000_0000, "R2 byte5 differs", 0);
        send_addr(stn ^ 48'h0000_0000_0080, "R2 byte0 differs", 0);
        send_addr({stn[7:0], stn[15:8], stn[23:16], stn[31:24], stn[39:32], stn[47:40]},
                  "R2 reversed order", 0);
    endtask

    task automatic t_hash(output logic [47:0] lo_addr);
        logic [47:0] cand;
        logic [47:0] hi_addr;
        int          s_lo;
        int          s_hi;
        bit          got_lo;
        bit          got_hi;
        got_lo = 0; got_hi = 0; s_lo = 0; s_hi = 0;
        lo_addr = '0; hi_addr = '0;
        for (int k = 0; k < 256; k++) begin
            cand = {8'(k), 32'h6655_4433, 8'h01};
            if (!got_lo && model_slot(cand) < 32) begin
                got_lo = 1; lo_addr = cand; s_lo = model_slot(cand);
            end
            if (!got_hi && model_slot(cand) >= 32) begin
                got_hi = 1; hi_addr = cand; s_hi = model_slot(cand);
            end
        end
        check("R6 low-half candidate found", got_lo, 1);
        check("R6 high-half candidate found", got_hi, 1);
        load_cfg(48'h0, 64'h1 << s_lo, 5'b00010);
        send_addr(lo_addr, "R7 low word slot hit", 1);
        send_addr(hi_addr, "R7 other slot misses", 0);
        load_cfg(48'h0, ~(64'h1 << s_lo), 5'b00010);
        send_addr(lo_addr, "R6 only own slot counts", 0);
        load_cfg(48'h0, 64'h1 << s_hi, 5'b00010);
        send_addr(hi_addr, "R7 high word slot hit", 1);
        load_cfg(48'h0, ~(64'h1 << s_hi), 5'b00010);
        send_addr(hi_addr, "R6 high slot cleared", 0);
        load_cfg(48'h0, '1, 5'b00010);
        send_addr(lo_addr ^ 48'h1, "R7 unicast ignores hash", 0);
        load_cfg(48'h0, 64'h1 << s_lo, 5'b00010);
    endtask

    task automatic t_restart(input logic [47:0] good);
        send_pair(48'h9988_7766_5501, good, 0, 1);
        send_pair(good, good, 1, 1);
    endtask

    initial begin : main
        logic [47:0] hit_addr;
        t_reset_state();
        t_unicast();
        t_multicast();
        t_broadcast();
        t_exact();
        t_hash(hit_addr);
        t_restart(hit_addr);
        load_cfg(48'h0, '0, 5'b00000);
        send_addr(48'h0123_4567_8901, "R10 all rules off", 0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule